// File: doc/BRIEF.md
# Pin Function Multiplexer Register Block

This block holds the configuration of a bank of pins behind a plain 32-bit register bus: a word address, a write strobe, write data and registered read data. For every pin it keeps a GPIO/peripheral selector, a 4-bit peripheral function code, a drive-strength code, a pull-resistor enable and direction, and an IO-voltage select. All of these settings drive dedicated per-pin outputs straight from their storage flops.

The selector, function, drive and voltage registers are guarded. Software first writes the bitwise complement of the word it intends to store into a key register at offset 0x000. That arms the guard, and the very next bus write is then checked. A guarded write whose data equals the complement of the stored key is committed. Any other guarded write is dropped and raises a sticky error output. Pull registers can be written at any time.

Drive codes follow a 24 mA full scale. With a 3-bit field the step is 3 mA, and with a 2-bit field it is 6 mA. Software stores (strength / step) − 1, so the all-ones code means full strength.

Top module: `pinmux_regs`

## Requirements
- R1: After synchronous reset all pins are GPIO (select 0), function codes are 0, drive codes are all ones (7 for 3-bit fields), pull enable and pull direction are 0, voltage select is all ones (3.3 V) and the error output is 0.
- R2: A write to offset 0x000 stores a key and arms the guard. An immediately following guarded write with data equal to the complement of the key is committed.
- R3: A guarded write made while unarmed, or with data that is not the complement of the key, leaves the register unchanged and sets lock_err_o. lock_err_o stays 1 until reset.
- R4: The arm is consumed by the next bus write of any kind (pull, unmapped or guarded). A second key write replaces the key and arms again.
- R5: The selector at 0x100 is guarded and has bit p for pin p, where 1 means peripheral and 0 means GPIO. It drives pin_periph_o[p].
- R6: The function words at 0x200, 0x204, 0x208 and 0x20C are guarded. Pin p uses bits [4*(p%8)+3 : 4*(p%8)] of word p/8 and drives pin_func_o[4p+3:4p].
- R7: The drive words at 0x300 to 0x30C are guarded. Pin p uses the low DRV_W bits of the 4-bit slot at 4*(p%8) of word p/8. The unused slot bits read as 0. The code drives pin_drive_o[DRV_W*p +: DRV_W].
- R8: Pull enable at 0x400 and pull direction at 0x404 (1 means pull-up) take writes without the key sequence and drive pull_en_o and pull_up_o.
- R9: The voltage register at 0x500 is guarded. Bit p = 1 selects 3.3 V and 0 selects 1.8 V for pin p, driven on volt_hi_o.
- R10: Read data appears on bus_rdata_o one cycle after the address is presented with bus_we_i low. Reading 0x000 returns 0 and leaves the armed state as it was.
- R11: A write to an unmapped or non-word-aligned offset changes no register, and a read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W (12) | Byte offset of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| pin_periph_o | output | 32 | Per-pin peripheral select |
| pin_func_o | output | 128 | Per-pin 4-bit function code |
| pin_drive_o | output | 32*DRV_W (96) | Per-pin drive code |
| pull_en_o | output | 32 | Per-pin pull enable |
| pull_up_o | output | 32 | Per-pin pull direction, 1 = up |
| volt_hi_o | output | 32 | Per-pin voltage select, 1 = 3.3 V |
| lock_err_o | output | 1 | Sticky rejected-write flag |

## Verification
A guard left armed by mistake would show up at the very next guarded write: a write that should be rejected would land, and the pin outputs would change one cycle later. A stale or lost key would instead keep a correct unlock sequence from committing, and the readback a cycle later would show the old word. A wrong key captured or compared by the guard raises lock_err_o on the clock edge of the rejected write. Mistakes in slot packing or masking appear as swapped nibbles or nonzero spare drive bits on the first readback or pin-output check after the write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [2:0] {
    RG_KEY, RG_SEL, RG_FUNC, RG_DRV, RG_PEN, RG_PDIR, RG_VOLT, RG_NONE
  } region_e;

  localparam int OFS_KEY  = 'h000;
  localparam int OFS_SEL  = 'h100;
  localparam int OFS_FUNC = 'h200;
  localparam int OFS_DRV  = 'h300;
  localparam int OFS_PEN  = 'h400;
  localparam int OFS_PDIR = 'h404;
  localparam int OFS_VOLT = 'h500;

  function automatic logic is_guarded(region_e r);
    return (r == RG_SEL) || (r == RG_FUNC) || (r == RG_DRV) || (r == RG_VOLT);
  endfunction

  // replicate a low-bit mask of width fw into every slot of size sw
  function automatic logic [63:0] slot_mask(int fw, int sw, int dw);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < dw; b++) begin
      if ((b % sw) < fw) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pinmux_decode.sv
module pinmux_decode
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 4,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  widx
);
  localparam int FUNC_END = OFS_FUNC + 4 * NWORDS;
  localparam int DRV_END  = OFS_DRV + 4 * NWORDS;

  always_comb begin
    region = RG_NONE;
    widx   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFS_KEY))       region = RG_KEY;
      else if (addr == ADDR_W'(OFS_SEL))  region = RG_SEL;
      else if (addr == ADDR_W'(OFS_PEN))  region = RG_PEN;
      else if (addr == ADDR_W'(OFS_PDIR)) region = RG_PDIR;
      else if (addr == ADDR_W'(OFS_VOLT)) region = RG_VOLT;
      else if (addr >= ADDR_W'(OFS_FUNC) && addr < ADDR_W'(FUNC_END)) begin
        region = RG_FUNC;
        widx   = IDX_W'((addr - ADDR_W'(OFS_FUNC)) >> 2);
      end else if (addr >= ADDR_W'(OFS_DRV) && addr < ADDR_W'(DRV_END)) begin
        region = RG_DRV;
        widx   = IDX_W'((addr - ADDR_W'(OFS_DRV)) >> 2);
      end
    end
  end
endmodule

// File: rtl/pinmux_guard.sv
module pinmux_guard
  import pinmux_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  region_e           region,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit_o,
  output logic              armed_o,
  output logic              err_o
);
  logic [DATA_W-1:0] key_q;
  logic              armed_q;
  logic              err_q;
  logic              match;

  assign match = armed_q && (wdata == ~key_q);

  always_comb begin
    commit_o = 1'b0;
    if (wr_en) begin
      if (is_guarded(region))                          commit_o = match;
      else if (region == RG_PEN || region == RG_PDIR) commit_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= '0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (wr_en) begin
      if (region == RG_KEY) begin
        key_q   <= wdata;
        armed_q <= 1'b1;
      end else begin
        armed_q <= 1'b0;
      end
      if (is_guarded(region) && !match) err_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign err_o   = err_q;

  // R4
  arm_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region != RG_KEY) |=> !armed_q);

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_KEY) |=> armed_q);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/pinmux_store.sv
module pinmux_store #(
  parameter int                DATA_W  = 32,
  parameter int                NWORDS  = 1,
  parameter int                IDX_W   = 1,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] MASK    = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rd_word,
  output logic [NWORDS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                          words[w] <= RST_VAL & MASK;
      else if (we && idx == IDX_W'(w))  words[w] <= wdata & MASK;
    end
    assign flat_o[w*DATA_W +: DATA_W] = words[w];
  end

  if (NWORDS == 1) begin : g_single
    assign rd_word = words[0];
  end else begin : g_multi
    assign rd_word = words[idx];
  end
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DRV_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic                      bus_we_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  output logic [DATA_W-1:0]         pin_periph_o,
  output logic [DATA_W*4-1:0]       pin_func_o,
  output logic [DATA_W*DRV_W-1:0]   pin_drive_o,
  output logic [DATA_W-1:0]         pull_en_o,
  output logic [DATA_W-1:0]         pull_up_o,
  output logic [DATA_W-1:0]         volt_hi_o,
  output logic                      lock_err_o
);
  localparam int NUM_PINS = DATA_W;
  localparam int SLOT     = 4;
  localparam int PER_WORD = DATA_W / SLOT;
  localparam int NWORDS   = NUM_PINS / PER_WORD;
  localparam int IDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [DATA_W-1:0] DRV_MASK = DATA_W'(slot_mask(DRV_W, SLOT, DATA_W));

  region_e          region;
  logic [IDX_W-1:0] widx;
  logic             commit, armed;
  logic [DATA_W-1:0] rd_sel, rd_func, rd_drv, rd_pen, rd_pdir, rd_volt;
  logic [NWORDS*DATA_W-1:0] drv_flat;

  pinmux_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr_i), .region(region), .widx(widx));

  pinmux_guard #(.DATA_W(DATA_W)) u_guard (
    .clk(clk), .rst(rst), .wr_en(bus_we_i), .region(region),
    .wdata(bus_wdata_i), .commit_o(commit), .armed_o(armed), .err_o(lock_err_o));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(1), .IDX_W(1)) u_sel (
    .clk(clk), .rst(rst), .we(commit && region == RG_SEL), .idx(1'b0),
    .wdata(bus_wdata_i), .rd_word(rd_sel), .flat_o(pin_periph_o));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_func (
    .clk(clk), .rst(rst), .we(commit && region == RG_FUNC), .idx(widx),
    .wdata(bus_wdata_i), .rd_word(rd_func), .flat_o(pin_func_o));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W),
                 .RST_VAL('1), .MASK(DRV_MASK)) u_drv (
    .clk(clk), .rst(rst), .we(commit && region == RG_DRV), .idx(widx),
    .wdata(bus_wdata_i), .rd_word(rd_drv), .flat_o(drv_flat));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(1), .IDX_W(1)) u_pen (
    .clk(clk), .rst(rst), .we(commit && region == RG_PEN), .idx(1'b0),
    .wdata(bus_wdata_i), .rd_word(rd_pen), .flat_o(pull_en_o));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(1), .IDX_W(1)) u_pdir (
    .clk(clk), .rst(rst), .we(commit && region == RG_PDIR), .idx(1'b0),
    .wdata(bus_wdata_i), .rd_word(rd_pdir), .flat_o(pull_up_o));

  pinmux_store #(.DATA_W(DATA_W), .NWORDS(1), .IDX_W(1), .RST_VAL('1)) u_volt (
    .clk(clk), .rst(rst), .we(commit && region == RG_VOLT), .idx(1'b0),
    .wdata(bus_wdata_i), .rd_word(rd_volt), .flat_o(volt_hi_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_drv_pin
    assign pin_drive_o[p*DRV_W +: DRV_W] = drv_flat[p*SLOT +: DRV_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else begin
      unique case (region)
        RG_SEL:  bus_rdata_o <= rd_sel;
        RG_FUNC: bus_rdata_o <= rd_func;
        RG_DRV:  bus_rdata_o <= rd_drv;
        RG_PEN:  bus_rdata_o <= rd_pen;
        RG_PDIR: bus_rdata_o <= rd_pdir;
        RG_VOLT: bus_rdata_o <= rd_volt;
        default: bus_rdata_o <= '0;
      endcase
    end
  end

  // R3
  sel_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && region == RG_SEL && !armed) |=> $stable(pin_periph_o));

  // R8
  pull_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && region == RG_PEN) |=> (pull_en_o == $past(bus_wdata_i)));

  // R10
  key_read_keeps_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_i && region == RG_KEY) |=> (armed == $past(armed)));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we_i && region == RG_NONE) |=> (bus_rdata_o == '0));
endmodule

// File: tb/sim_pinmux_regs.sv
`timescale 1ns/1ps
module sim_pinmux_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, periph, pen, pup, volt;
  logic [127:0] func;
  logic [95:0]  drive;
  logic         err;
  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  pinmux_regs u0 (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pin_periph_o(periph), .pin_func_o(func),
    .pin_drive_o(drive), .pull_en_o(pen), .pull_up_o(pup), .volt_hi_o(volt),
    .lock_err_o(err));

  localparam int NV = 10;
  // R5 R6 R7 R8 R9 R11 vectors: unlock flag, offset, data, expected readback
  localparam bit          V_ULK [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 0, 0};
  localparam logic [11:0] V_ADR [NV] = '{12'h100, 12'h200, 12'h20C, 12'h304, 12'h300,
                                         12'h400, 12'h404, 12'h500, 12'h600, 12'h102};
  localparam logic [31:0] V_DAT [NV] = '{32'h0000_00F0, 32'h8765_4321, 32'hDEAD_BEEF,
                                         32'hFFFF_FFFF, 32'h1234_5678, 32'h0F0F_0F0F,
                                         32'hA5A5_A5A5, 32'h0000_FFFF, 32'h0000_1234,
                                         32'hFFFF_FFFF};
  localparam logic [31:0] V_EXP [NV] = '{32'h0000_00F0, 32'h8765_4321, 32'hDEAD_BEEF,
                                         32'h7777_7777, 32'h1234_5670, 32'h0F0F_0F0F,
                                         32'hA5A5_A5A5, 32'h0000_FFFF, 32'h0000_0000,
                                         32'h0000_0000};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 periph", periph, 32'h0);
    chk("R1 func", func[31:0] | func[127:96], 32'h0);
    chk("R1 drive", drive[31:0], 32'hFFFF_FFFF);
    chk("R1 pull_en", pen, 32'h0);
    chk("R1 pull_up", pup, 32'h0);
    chk("R1 volt", volt, 32'hFFFF_FFFF);
    chk("R1 err", {31'b0, err}, 32'h0);
    rd(12'h300, r); chk("R1 drive readback", r, 32'h7777_7777);

    for (int i = 0; i < NV; i++) begin
      if (V_ULK[i]) wr(12'h000, ~V_DAT[i]);
      wr(V_ADR[i], V_DAT[i]);
      rd(V_ADR[i], r);
      chk($sformatf("R2 vector %0d", i), r, V_EXP[i]);
    end
    chk("R2 no error after valid sequences", {31'b0, err}, 32'h0);
    chk("R5 periph out", periph, 32'h0000_00F0);
    chk("R6 pin1 func", {28'b0, func[7:4]}, 32'h2);
    chk("R6 pin31 func", {28'b0, func[127:124]}, 32'hD);
    chk("R7 pin0 drive", {29'b0, drive[2:0]}, 32'h0);
    chk("R7 pin8 drive", {29'b0, drive[26:24]}, 32'h7);
    chk("R8 pull_up out", pup, 32'hA5A5_A5A5);
    chk("R9 volt out", volt, 32'h0000_FFFF);
    rd(12'h100, r); chk("R11 misaligned write ignored", r, 32'h0000_00F0);

    // R3 unarmed guarded write
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, r); chk("R3 unarmed rejected", r, 32'h0000_00F0);
    chk("R3 err set", {31'b0, err}, 32'h1);
    // R3 wrong complement
    wr(12'h000, ~32'h1); wr(12'h100, 32'h2);
    rd(12'h100, r); chk("R3 wrong key rejected", r, 32'h0000_00F0);
    // R4 arm consumed by a pull write
    wr(12'h000, ~32'h55); wr(12'h400, 32'h0000_0003); wr(12'h100, 32'h55);
    rd(12'h100, r); chk("R4 consumed arm", r, 32'h0000_00F0);
    chk("R4 pull write landed", pen, 32'h0000_0003);
    // R4 arm consumed by unmapped write
    wr(12'h000, ~32'h77); wr(12'h700, 32'h0); wr(12'h500, 32'h77);
    chk("R4 consumed by unmapped", volt, 32'h0000_FFFF);
    // R4 re-key
    wr(12'h000, ~32'h11); wr(12'h000, ~32'h22); wr(12'h100, 32'h22);
    rd(12'h100, r); chk("R4 latest key wins", r, 32'h22);
    // R10 key read returns zero and keeps arm
    wr(12'h000, ~32'h33);
    rd(12'h000, r); chk("R10 key reads zero", r, 32'h0);
    wr(12'h100, 32'h33);
    chk("R10 arm kept across read", periph, 32'h33);
    chk("R3 err sticky", {31'b0, err}, 32'h1);
    // R1 reset clears everything again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 err cleared", {31'b0, err}, 32'h0);
    chk("R1 periph cleared", periph, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule